// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between the execute stage of a 32-bit load/store core and a word-organised data RAM with byte addressing. For each request it takes the base register value, the raw instruction word, a flag that picks load or store format, and the register data to store. It decodes the split 12-bit offset for the chosen format, forms the byte address, and produces the word address, per-byte write enables and store data moved into the correct byte lanes. Little-endian order is used: the byte at the lowest address sits in bits [7:0] of a word.

Load data comes back from a synchronous RAM one cycle after the request. The block keeps the request's width code and low address bits in a register for that cycle. It then picks the addressed byte, halfword or word out of the returned word and extends it with sign or zero to 32 bits. Requests with an unaligned halfword or word address, or with a width code that does not exist, are flagged. They produce no byte enables and issue no memory request.

Top module: `lsu_lane_align`

## Requirements
- R1: For a load, the byte address equals the base value plus the sign-extended 12-bit offset held in instruction bits [31:20].
- R2: For a store, the offset's bits [11:5] come from instruction bits [31:25] and its bits [4:0] from instruction bits [11:7]. The offset is sign-extended and added to the base value.
- R3: The word address output is the byte address with its two low bits dropped.
- R4: The width code is instruction bits [14:12]. Code 000 or 100 gives byte enables 4'b0001 shifted left by address bits [1:0]. Code 001 or 101 gives 4'b0011 shifted left by 2 when address bit 1 is set. Code 010 gives 4'b1111.
- R5: On an accepted store, the write data is the store operand shifted left by 8 times address bits [1:0]. Every lane whose byte enable is 0 reads 0. Code 000 writes only bits [7:0] of the operand, code 001 only bits [15:0], and code 010 all 32 bits.
- R6: A halfword request with address bit 0 set, or a word request with address bits [1:0] not 00, raises the misaligned flag. It then drives all byte enables to 0 and leaves memory unchanged.
- R7: Load codes 011, 110 and 111 and store codes 011 to 111 raise the illegal flag. The misaligned flag stays low, all byte enables are 0, no load result is produced, and memory is left unchanged.
- R8: One cycle after an accepted load with code 000 or 100, the result is the addressed byte, sign-extended for 000 and zero-extended for 100.
- R9: One cycle after an accepted load with code 001 or 101, the result is the addressed halfword, sign-extended for 001 and zero-extended for 101.
- R10: One cycle after an accepted load with code 010, the result is the whole read word.
- R11: The load-valid output is high in exactly those cycles that follow a request that was a load and was neither illegal nor misaligned.
- R12: During and after synchronous reset, until a load has been accepted, load-valid is 0. The load result reads 0 in every cycle in which load-valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| is_store | input | 1 | 1 selects store format, 0 load format |
| base_val | input | 32 | Base register value |
| insn | input | 32 | Instruction word |
| st_data | input | 32 | Register data to store |
| rd_word | input | 32 | RAM read word, one cycle after the request |
| eff_addr | output | 32 | Byte address |
| word_addr | output | 30 | RAM word address |
| byte_en | output | 4 | Per-lane enables |
| wr_data | output | 32 | Lane-steered store data |
| mem_req | output | 1 | Request goes to RAM |
| mem_we | output | 1 | RAM write strobe |
| misaligned | output | 1 | Unaligned halfword or word access |
| illegal | output | 1 | Unknown width code |
| ld_valid | output | 1 | Load result valid this cycle |
| ld_result | output | 32 | Extended load result |

## Verification
The address, word address, byte enables, write data, request strobes and both flags are combinational from the request. The bench samples them 2 ns after the falling edge at which it drives the request, in the same cycle. The load result and load-valid are due one cycle later, after the RAM model's read register and the block's width and offset register. The bench reads them just after the next falling edge, at which point the request has already been dropped. Store effects and the lack of any effect from faulting stores are observed through word loads that follow, which are compared with a bench-side memory image.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  // Access size, taken from width code bits [1:0]
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Legal width codes differ between the two formats
  function automatic logic code_legal(input logic st, input logic [2:0] code);
    if (st) return (code == 3'b000) || (code == 3'b001) || (code == 3'b010);
    return (code == 3'b000) || (code == 3'b001) || (code == 3'b010) ||
           (code == 3'b100) || (code == 3'b101);
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic            is_store,
  input  logic [XLEN-1:0] base_val,
  input  logic [31:0]     insn,
  output logic [XLEN-1:0] eff_addr
);

  logic [IMM_W-1:0] imm_ld;
  logic [IMM_W-1:0] imm_st;
  logic [IMM_W-1:0] imm_sel;
  logic [XLEN-1:0]  imm_ext;
  logic             unused_insn;

  assign imm_ld  = insn[31:20];
  assign imm_st  = {insn[31:25], insn[11:7]};
  assign imm_sel = is_store ? imm_st : imm_ld;
  assign imm_ext = {{(XLEN-IMM_W){imm_sel[IMM_W-1]}}, imm_sel};
  assign eff_addr = base_val + imm_ext;

  assign unused_insn = ^{insn[19:12], insn[6:0]};

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_lane_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NLANES = XLEN / 8,
  parameter int OFFS_W = $clog2(NLANES)
) (
  input  logic              req_valid,
  input  logic              is_store,
  input  logic [2:0]        funct3,
  input  logic [OFFS_W-1:0] offs,
  input  logic [XLEN-1:0]   st_data,
  output logic [NLANES-1:0] byte_en,
  output logic [XLEN-1:0]   wr_data,
  output logic              misaligned,
  output logic              illegal
);

  logic [1:0]        size;
  logic              legal;
  logic              mis_raw;
  logic [NLANES-1:0] width_mask;
  logic [XLEN-1:0]   shifted;

  assign size  = funct3[1:0];
  assign legal = code_legal(is_store, funct3);

  always_comb begin
    case (size)
      SZ_BYTE: begin width_mask = NLANES'(1); mis_raw = 1'b0;            end
      SZ_HALF: begin width_mask = NLANES'(3); mis_raw = offs[0];         end
      default: begin width_mask = '1;         mis_raw = (offs != '0);    end
    endcase
  end

  assign illegal    = req_valid & ~legal;
  assign misaligned = req_valid & legal & mis_raw;
  assign byte_en    = (req_valid & legal & ~mis_raw) ? (width_mask << offs) : '0;

  assign shifted = st_data << {offs, 3'b000};

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign wr_data[8*g +: 8] = byte_en[g] ? shifted[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NLANES = XLEN / 8,
  parameter int OFFS_W = $clog2(NLANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [2:0]        funct3,
  input  logic [OFFS_W-1:0] offs,
  input  logic [XLEN-1:0]   rd_word,
  output logic              ld_valid,
  output logic [XLEN-1:0]   ld_result
);

  logic              vld_q;
  logic [2:0]        code_q;
  logic [OFFS_W-1:0] offs_q;
  logic [XLEN-1:0]   aligned;
  logic [XLEN-1:0]   extended;
  logic              sgn;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      code_q <= 3'b000;
      offs_q <= '0;
    end else begin
      vld_q <= accept;
      if (accept) begin
        code_q <= funct3;
        offs_q <= offs;
      end
    end
  end

  assign aligned = rd_word >> {offs_q, 3'b000};

  always_comb begin
    sgn = 1'b0;
    case (code_q[1:0])
      SZ_BYTE: begin
        sgn      = aligned[7] & ~code_q[2];
        extended = {{(XLEN-8){sgn}}, aligned[7:0]};
      end
      SZ_HALF: begin
        sgn      = aligned[15] & ~code_q[2];
        extended = {{(XLEN-16){sgn}}, aligned[15:0]};
      end
      default: extended = rd_word;
    endcase
  end

  assign ld_valid  = vld_q;
  assign ld_result = vld_q ? extended : '0;

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 12,
  parameter int NLANES = XLEN / 8,
  parameter int OFFS_W = $clog2(NLANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   is_store,
  input  logic [XLEN-1:0]        base_val,
  input  logic [31:0]            insn,
  input  logic [XLEN-1:0]        st_data,
  input  logic [XLEN-1:0]        rd_word,
  output logic [XLEN-1:0]        eff_addr,
  output logic [XLEN-OFFS_W-1:0] word_addr,
  output logic [NLANES-1:0]      byte_en,
  output logic [XLEN-1:0]        wr_data,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic                   misaligned,
  output logic                   illegal,
  output logic                   ld_valid,
  output logic [XLEN-1:0]        ld_result
);

  logic [2:0]        funct3;
  logic [OFFS_W-1:0] offs;
  logic              ok;

  assign funct3 = insn[14:12];

  lsu_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addr (
    .is_store (is_store),
    .base_val (base_val),
    .insn     (insn),
    .eff_addr (eff_addr)
  );

  assign offs      = eff_addr[OFFS_W-1:0];
  assign word_addr = eff_addr[XLEN-1:OFFS_W];

  lsu_store_steer #(.XLEN(XLEN), .NLANES(NLANES), .OFFS_W(OFFS_W)) u_steer (
    .req_valid  (req_valid),
    .is_store   (is_store),
    .funct3     (funct3),
    .offs       (offs),
    .st_data    (st_data),
    .byte_en    (byte_en),
    .wr_data    (wr_data),
    .misaligned (misaligned),
    .illegal    (illegal)
  );

  assign ok      = req_valid & ~misaligned & ~illegal;
  assign mem_req = ok;
  assign mem_we  = ok & is_store;

  lsu_load_extract #(.XLEN(XLEN), .NLANES(NLANES), .OFFS_W(OFFS_W)) u_ext (
    .clk       (clk),
    .rst       (rst),
    .accept    (ok & ~is_store),
    .funct3    (funct3),
    .offs      (offs),
    .rd_word   (rd_word),
    .ld_valid  (ld_valid),
    .ld_result (ld_result)
  );

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int NLANES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              is_store,
  input logic [2:0]        funct3,
  input logic [NLANES-1:0] byte_en,
  input logic              mem_req,
  input logic              misaligned,
  input logic              illegal,
  input logic              ld_valid
);

  a_r6_mis_blocks: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (byte_en == '0) && !mem_req);

  a_r7_illegal_blocks: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (byte_en == '0) && !mem_req && !misaligned);

  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
    (mem_req && funct3[1:0] == 2'b00) |-> $countones(byte_en) == 1);

  a_r4_word_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (mem_req && funct3[1:0] == 2'b10) |-> byte_en == '1);

  a_r11_load_returns: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !is_store) |=> ld_valid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || is_store || illegal || misaligned) |=> !ld_valid);

endmodule

bind lsu_lane_align lsu_lane_align_chk #(.NLANES(NLANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .is_store   (is_store),
  .funct3     (insn[14:12]),
  .byte_en    (byte_en),
  .mem_req    (mem_req),
  .misaligned (misaligned),
  .illegal    (illegal),
  .ld_valid   (ld_valid)
);

// File: tb/tb_lsu_lane_align.sv
module tb_lsu_lane_align;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        is_store = 1'b0;
  logic [31:0] base_val = '0;
  logic [31:0] insn = '0;
  logic [31:0] st_data = '0;
  logic [31:0] rd_q = '0;
  logic [31:0] eff_addr;
  logic [29:0] word_addr;
  logic [3:0]  byte_en;
  logic [31:0] wr_data;
  logic        mem_req, mem_we, misaligned, illegal, ld_valid;
  logic [31:0] ld_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mem     [16];
  logic [31:0] ref_mem [16];

  always #10 clk = ~clk;

  lsu_lane_align dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .is_store(is_store),
    .base_val(base_val), .insn(insn), .st_data(st_data), .rd_word(rd_q),
    .eff_addr(eff_addr), .word_addr(word_addr), .byte_en(byte_en),
    .wr_data(wr_data), .mem_req(mem_req), .mem_we(mem_we),
    .misaligned(misaligned), .illegal(illegal),
    .ld_valid(ld_valid), .ld_result(ld_result)
  );

  // Synchronous RAM model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we)
      for (int i = 0; i < 4; i++)
        if (byte_en[i]) mem[word_addr[3:0]][8*i +: 8] <= wr_data[8*i +: 8];
    if (mem_req && !is_store) rd_q <= mem[word_addr[3:0]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic st, input logic [2:0] f3, input logic [31:0] base,
                        input logic [11:0] imm, input logic [31:0] sd);
    logic [31:0] ea, sh, w, exp_ld, exp_wd;
    logic [3:0]  exp_be;
    logic        legal, mis, ok;
    ea = base + {{20{imm[11]}}, imm};
    legal = st ? (f3 <= 3'd2) : (f3 <= 3'd2 || f3 == 3'd4 || f3 == 3'd5);
    mis = legal && ((f3[1:0] == 2'd1 && ea[0]) || (f3[1:0] == 2'd2 && ea[1:0] != 2'd0));
    ok = legal && !mis;
    exp_be = 4'b0000;
    if (ok) begin
      if (f3[1:0] == 2'd0)      exp_be = 4'b0001 << ea[1:0];
      else if (f3[1:0] == 2'd1) exp_be = ea[1] ? 4'b1100 : 4'b0011;
      else                      exp_be = 4'b1111;
    end
    sh = sd << (8 * ea[1:0]);
    exp_wd = 32'h0;
    for (int i = 0; i < 4; i++) if (exp_be[i]) exp_wd[8*i +: 8] = sh[8*i +: 8];
    w = ref_mem[ea[5:2]];
    sh = w >> (8 * ea[1:0]);
    case (f3)
      3'd0:    exp_ld = {{24{sh[7]}}, sh[7:0]};
      3'd4:    exp_ld = {24'h0, sh[7:0]};
      3'd1:    exp_ld = {{16{sh[15]}}, sh[15:0]};
      3'd5:    exp_ld = {16'h0, sh[15:0]};
      default: exp_ld = w;
    endcase

    @(negedge clk);
    req_valid = 1'b1;
    is_store  = st;
    base_val  = base;
    st_data   = sd;
    insn = st ? {imm[11:5], 5'd7, 5'd3, f3, imm[4:0], 7'b0100011}
              : {imm, 5'd9, f3, 5'd4, 7'b0000011};
    #2;
    chk(st ? "R2 addr" : "R1 addr", eff_addr, ea);
    chk("R3 word", {2'b00, word_addr}, {2'b00, ea[31:2]});
    chk(!legal ? "R7 be" : mis ? "R6 be" : "R4 be", {28'h0, byte_en}, {28'h0, exp_be});
    chk("R6 flag", {31'h0, misaligned}, {31'h0, mis});
    chk("R7 flag", {31'h0, illegal}, {31'h0, !legal});
    chk("R6 req", {30'h0, mem_req, mem_we}, {30'h0, ok, ok && st});
    if (st && ok) chk("R5 data", wr_data, exp_wd);
    @(negedge clk);
    req_valid = 1'b0;
    is_store  = 1'b0;
    #1;
    chk("R11 valid", {31'h0, ld_valid}, {31'h0, ok && !st});
    if (ok && !st) begin
      if (f3[1:0] == 2'd0)      chk("R8 byte", ld_result, exp_ld);
      else if (f3[1:0] == 2'd1) chk("R9 half", ld_result, exp_ld);
      else                      chk("R10 word", ld_result, exp_ld);
    end else begin
      chk("R12 zero", ld_result, 32'h0);
    end
    if (st && ok)
      for (int i = 0; i < 4; i++)
        if (exp_be[i]) ref_mem[ea[5:2]][8*i +: 8] = exp_wd[8*i +: 8];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0]  lcodes [5];
    lcodes = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5};
    for (int i = 0; i < 16; i++) ref_mem[i] = 32'h0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset valid", {31'h0, ld_valid}, 32'h0);
    chk("R12 reset result", ld_result, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 idle valid", {31'h0, ld_valid}, 32'h0);
    chk("R12 idle result", ld_result, 32'h0);

    // Fill memory with word stores, mixed sign bits per lane
    for (int w = 0; w < 16; w++)
      access(1'b1, 3'd2, 32'h0000_2000, 12'(w * 4),
             32'h8F7E_6D5C ^ (w * 32'h1113_0917));

    // Load sweep: every legal code, every offset, positive and negative offsets
    for (int c = 0; c < 5; c++)
      for (int o = 0; o < 4; o++)
        for (int w = 0; w < 16; w += 5) begin
          access(1'b0, lcodes[c], 32'h0000_1000 + w * 4 + o, 12'h000, 32'h0);
          access(1'b0, lcodes[c], 32'h0000_3010 + w * 4 + o, 12'hFF0, 32'h0);
        end

    // Store sweep with split offsets, then read back the word
    for (int c = 0; c < 3; c++)
      for (int o = 0; o < 4; o++)
        for (int k = 0; k < 2; k++) begin
          logic [11:0] imm;
          logic [31:0] tgt;
          imm = k ? 12'h835 : 12'h7E4;
          tgt = 32'h0000_4000 + (3 + 6 * k) * 4 + o;
          access(1'b1, 3'(c), tgt - {{20{imm[11]}}, imm},
                 imm, 32'hA1B2_C3D4 ^ {4{8'(o * 17 + c)}});
          access(1'b0, 3'd2, tgt & 32'hFFFF_FFFC, 12'h000, 32'h0);
        end

    // Illegal codes: no lanes, no result, no memory change
    for (int c = 3; c < 8; c++) begin
      if (c == 3 || c > 5) access(1'b0, 3'(c), 32'h0000_0020, 12'h004, 32'h0);
      access(1'b1, 3'(c), 32'h0000_0020, 12'h004, 32'hDEAD_BEEF);
      access(1'b0, 3'd2, 32'h0000_0024, 12'h000, 32'h0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule